// File: doc/BRIEF.md
# Mailbox Interrupt Flags

This block lets the two ports of a shared two-port memory signal each other through two mailbox words at the top of the address space. Each port owns one mailbox. When the partner writes into a port's mailbox, that port's active-low interrupt output drops. When the owning port reads its mailbox, the output returns high. The block watches each port's enable, read/write, output enable and address, and it samples them on a common clock. It produces only the two flags. The mailbox contents stay in the ordinary memory array, which holds an arbitrary message of the user's choosing, and that array is outside this block.

The uppermost address (all ones, 7FFF at the default 15-bit width) is the right port's mailbox. The address one below it (7FFE) is the left port's mailbox. The busy indication from the collision arbiter gates every access. While the acting port's busy input is low, its access neither sets nor clears a flag. Each flag is a register, so it changes on the clock edge that samples the access.

Top module: `mbox_irq`

## Requirements
- R1: While `rst_n` is low, and afterwards until a set occurs, `l_irq_n` and `r_irq_n` are both high.
- R2: A left-port write (`l_ce_n`=0, `l_we_n`=0) to the all-ones address, with `l_busy_n`=1, drives `r_irq_n` low at the clock edge that samples it.
- R3: A right-port access with `r_ce_n`=0 and `r_oe_n`=0 to the all-ones address, with `r_busy_n`=1, drives `r_irq_n` high at the sampling edge. The level of `r_we_n` does not matter.
- R4: A right-port write (`r_ce_n`=0, `r_we_n`=0) to the all-ones address minus one, with `r_busy_n`=1, drives `l_irq_n` low at the sampling edge.
- R5: A left-port access with `l_ce_n`=0 and `l_oe_n`=0 to the all-ones address minus one, with `l_busy_n`=1, drives `l_irq_n` high at the sampling edge. The level of `l_we_n` does not matter.
- R6: When the acting port's busy input is low (0), its access neither sets nor clears either flag.
- R7: If a set and a clear of the same flag are sampled on the same edge, the flag goes low (the set wins).
- R8: An access that does not meet any of the conditions above leaves both flags unchanged. This covers other addresses, an enable that is high, a read of the partner's mailbox, and a clear attempt with output enable high.
- R9: The two flags are independent. Both can be set on the same edge, or both cleared on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce_n | input | 1 | Left port enable, active low |
| l_we_n | input | 1 | Left port read/write, low means write |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | ADDR_W | Left port address |
| l_busy_n | input | 1 | Left port busy from the arbiter, low means blocked |
| r_ce_n | input | 1 | Right port enable, active low |
| r_we_n | input | 1 | Right port read/write, low means write |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | ADDR_W | Right port address |
| r_busy_n | input | 1 | Right port busy from the arbiter, low means blocked |
| l_irq_n | output | 1 | Interrupt to the left port, active low |
| r_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
One flag can be set by the partner's write and cleared by its owner's read on the same edge. The bench provokes this by having the left port write the right mailbox while the right port reads it, and then the mirror case on the other flag. It expects the flag low afterwards. It also clears both flags on one edge and sets both on one edge, and it checks that the two sides do not disturb each other.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy_n,
  input  logic              r_ce_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy_n,
  output logic              l_irq_n,
  output logic              r_irq_n
);

  localparam logic [ADDR_W-1:0] R_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] L_BOX = R_BOX - 1'b1;

  logic l_wr, l_rd, r_wr, r_rd;
  logic set_r, clr_r, set_l, clr_l;

  assign l_wr = !l_ce_n && !l_we_n && l_busy_n;
  assign l_rd = !l_ce_n && !l_oe_n && l_busy_n;
  assign r_wr = !r_ce_n && !r_we_n && r_busy_n;
  assign r_rd = !r_ce_n && !r_oe_n && r_busy_n;

  assign set_r = l_wr && (l_addr == R_BOX);
  assign clr_r = r_rd && (r_addr == R_BOX);
  assign set_l = r_wr && (r_addr == L_BOX);
  assign clr_l = l_rd && (l_addr == L_BOX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     r_irq_n <= 1'b1;
    else if (set_r) r_irq_n <= 1'b0;
    else if (clr_r) r_irq_n <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     l_irq_n <= 1'b1;
    else if (set_l) l_irq_n <= 1'b0;
    else if (clr_l) l_irq_n <= 1'b1;
  end

endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_ce_n,
  input logic              l_we_n,
  input logic              l_oe_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy_n,
  input logic              r_ce_n,
  input logic              r_we_n,
  input logic              r_oe_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy_n,
  input logic              l_irq_n,
  input logic              r_irq_n
);

  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BELOW = TOP - 1'b1;

  wire lw_top = !l_ce_n && !l_we_n && l_busy_n && l_addr == TOP;
  wire rr_top = !r_ce_n && !r_oe_n && r_busy_n && r_addr == TOP;
  wire rw_bel = !r_ce_n && !r_we_n && r_busy_n && r_addr == BELOW;
  wire lr_bel = !l_ce_n && !l_oe_n && l_busy_n && l_addr == BELOW;

  always @(negedge clk)
    if (!rst_n) a_r1_idle_in_reset: assert (l_irq_n && r_irq_n);

  a_r2_left_sets_right: assert property (@(posedge clk) disable iff (!rst_n)
    lw_top |=> !r_irq_n);
  a_r3_right_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_top && !lw_top) |=> r_irq_n);
  a_r4_right_sets_left: assert property (@(posedge clk) disable iff (!rst_n)
    rw_bel |=> !l_irq_n);
  a_r5_left_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_bel && !rw_bel) |=> l_irq_n);
  a_r8_right_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!lw_top && !rr_top) |=> $stable(r_irq_n));
  a_r8_left_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw_bel && !lr_bel) |=> $stable(l_irq_n));

endmodule

bind mbox_irq mbox_irq_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/mbox_irq_tb.sv
`timescale 1ns/1ps
module mbox_irq_tb_top;
  localparam int AW = 15;
  localparam logic [AW-1:0] TOP = 15'h7FFF;
  localparam logic [AW-1:0] BEL = 15'h7FFE;

  logic clk = 0, rst_n = 0;
  logic l_ce_n = 1, l_we_n = 1, l_oe_n = 1, l_busy_n = 1;
  logic r_ce_n = 1, r_we_n = 1, r_oe_n = 1, r_busy_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;

  always #2.5 clk = ~clk;

  mbox_irq #(.ADDR_W(AW)) dut_i (.*);

  typedef struct { logic el; logic er; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic step(input logic lce, lwe, loe, input logic [AW-1:0] la, input logic lb,
                      input logic rce, rwe, roe, input logic [AW-1:0] ra, input logic rb,
                      input logic el, er, input string tag);
    item_t it;
    @(negedge clk);
    l_ce_n = lce; l_we_n = lwe; l_oe_n = loe; l_addr = la; l_busy_n = lb;
    r_ce_n = rce; r_we_n = rwe; r_oe_n = roe; r_addr = ra; r_busy_n = rb;
    it.el = el; it.er = er; it.tag = tag;
    q.push_back(it);
  endtask

  always begin
    @(posedge clk); #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (l_irq_n !== it.el || r_irq_n !== it.er) begin
        errors++;
        $display("FAIL %s: l_irq_n/r_irq_n actual %b%b expected %b%b",
                 it.tag, l_irq_n, r_irq_n, it.el, it.er);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset
    for (int i = 0; i < 3; i++) step(1,1,1,0,1, 1,1,1,0,1, 1,1, "R1 reset");
    @(negedge clk); rst_n = 1;
    step(1,1,1,0,1, 1,1,1,0,1, 1,1, "R1 after release");
    // R2 left writes right mailbox
    step(0,0,1,TOP,1, 1,1,1,0,1, 1,0, "R2 set right");
    step(1,1,1,0,1, 1,1,1,0,1, 1,0, "R8 idle hold");
    step(0,1,0,TOP,1, 1,1,1,0,1, 1,0, "R8 left read of right box");
    step(1,1,1,0,1, 0,1,0,BEL,1, 1,0, "R8 right read wrong box");
    step(1,1,1,0,1, 0,1,1,TOP,1, 1,0, "R8 right oe high");
    step(1,1,1,0,1, 0,1,0,TOP,0, 1,0, "R6 right clear blocked");
    step(1,1,1,0,1, 0,0,0,TOP,1, 1,1, "R3 clear with we low");
    step(0,0,1,TOP,0, 1,1,1,0,1, 1,1, "R6 left set blocked");
    // R4 right writes left mailbox
    step(1,1,1,0,1, 0,0,1,BEL,1, 0,1, "R4 set left");
    step(0,0,1,BEL,1, 1,1,1,0,1, 0,1, "R8 left write own box oe high");
    step(0,1,0,BEL,0, 1,1,1,0,1, 0,1, "R6 left clear blocked");
    step(0,1,0,BEL,1, 1,1,1,0,1, 1,1, "R5 clear left");
    // R9 both at once
    step(0,0,1,TOP,1, 0,0,1,BEL,1, 0,0, "R9 set both");
    step(0,1,0,BEL,1, 0,1,0,TOP,1, 1,1, "R9 clear both");
    // R7 set wins
    step(0,0,1,TOP,1, 0,1,0,TOP,1, 1,0, "R7 right set beats clear");
    step(0,1,0,BEL,1, 0,0,1,BEL,1, 0,0, "R7 left set beats clear");
    step(0,1,0,BEL,1, 0,1,0,TOP,1, 1,1, "R9 clear both again");
    step(1,1,1,0,1, 0,0,1,BEL,0, 1,1, "R6 right set blocked");
    step(1,0,1,TOP,1, 1,1,1,0,1, 1,1, "R8 left ce high");
    step(1,1,1,0,1, 0,0,1,TOP,1, 1,1, "R8 right write own box");
    step(0,0,1,15'h1234,1, 0,0,1,15'h0001,1, 1,1, "R8 other addresses");
    step(1,1,1,0,1, 1,1,1,0,1, 1,1, "R8 final idle");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule